// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is one DMA channel. It reads four-word descriptors from memory, then copies data from a source address to a target address. Each copy moves a burst of up to 32 bytes: the channel first reads the whole burst into a local buffer and then writes it out. After each burst it writes the remaining byte count back into the command word. When the count reaches zero, the channel either stops or loads the descriptor named by the current next-pointer. The fetch of that descriptor can branch 32 bytes further when the compare-status input is set. A peripheral request input can gate the transfer. When that request falls before the count reaches zero, the channel raises an end-of-receive flag and then stops, jumps to the next descriptor or waits, as its control inputs select.

The register block drives the channel through plain control pins: a start pulse, the mode enables and the programmed descriptor values. It reads back the live pointer, addresses and command word, the active and stopped indications and three sticky flags. It clears the flags with a per-bit pulse. The memory side is a valid/ready master port that moves one beat per transfer. Once the channel raises `mem_valid`, it holds the address, direction, size and write data unchanged until the cycle in which `mem_ready` is high. In that accepting cycle the memory returns read data on `mem_rdata`, right-aligned. The memory may keep `mem_ready` low for any number of cycles. `mem_ready` has no effect while `mem_valid` is low.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, `active`=0, `stop_flag`=1, the start, end and end-of-receive flags are 0, and `mem_valid`=0. `mem_valid` is never high while `active` is 0.
- R2: When `run_start` pulses with `nodesc_mode`=0, the channel reads four 4-byte words (`mem_size`=2) from the pointer on `prog_desc`, with its low 4 bits cleared, at offsets +0, +4, +8 and +12. The words are, in order: next pointer, source address, target address, command.
- R3: When the pointer has bit 1 set and `cmp_status` is 1, the descriptor fetch address is increased by 32. Otherwise bit 1 has no effect on the fetch address.
- R4: Command bits 15:14 set the beat width. Code 2 gives 2 bytes (`mem_size`=1), code 3 gives 4 bytes (`mem_size`=2), and codes 0 and 1 give 1 byte (`mem_size`=0). Bits 17:16 set the burst size: code 0 gives 4 bytes, 1 gives 8, 2 gives 16 and 3 gives 32. Each burst moves the smaller of the burst size and the remaining length. All reads of a burst complete before its first write, and the data written equals the data read.
- R5: Command bit 31 makes the source address advance by the width after every read beat. Command bit 30 does the same for the target address after every write beat. When a bit is 0, that address stays fixed.
- R6: After every burst, command bits 12:0 (the remaining byte count, seen on `cur_cmd`) are reduced by the bytes moved.
- R7: When the remaining count reaches 0, the channel stops if any of the following holds: bit 0 of the current next pointer is 1, `nodesc_mode` is 1, or `eor_stop_en` is 1. Stopping sets `active`=0 and `stop_flag`=1. Otherwise the channel fetches the next descriptor from the next pointer.
- R8: Loading a descriptor whose command bit 22 is 1 sets `start_flag`. Reaching a count of 0 with command bit 21 set sets `end_flag`.
- R9: Command bits 29 (source) and 28 (target) enable flow control. When either bit is set, no burst starts while `periph_req` is 0. The matching address has its low two bits cleared when the descriptor is loaded.
- R10: Under flow control, a burst that ends with `periph_req`=0 and a nonzero remaining count sets `eor_flag`. The channel then stops if `eor_stop_en` is 1. Otherwise, if `eor_jump_en` is 1 and `nodesc_mode` is 0, it fetches the next descriptor. Failing both, it waits for the request.
- R11: When `run_start` pulses with `nodesc_mode`=1, the channel copies `prog_desc`, `prog_src`, `prog_dst` and `prog_cmd` and starts the transfer with no memory fetch. Command bit 22 then raises no start flag.
- R12: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_write`, `mem_size` and, for writes, `mem_wdata` hold their values into the next cycle.
- R13: `flag_clr` bit 0 clears `start_flag`, bit 1 clears `end_flag` and bit 2 clears `eor_flag`. A clear bit leaves the other flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | One-cycle start pulse, taken while idle |
| nodesc_mode | input | 1 | Run from the programmed values without descriptor fetches |
| eor_stop_en | input | 1 | Stop on end-of-receive or at the end of the count |
| eor_jump_en | input | 1 | Fetch the next descriptor on end-of-receive |
| cmp_status | input | 1 | Compare status used by the branch |
| prog_desc | input | ADDR_W | Programmed next-descriptor pointer |
| prog_src | input | ADDR_W | Programmed source address (no-fetch mode) |
| prog_dst | input | ADDR_W | Programmed target address (no-fetch mode) |
| prog_cmd | input | 32 | Programmed command word (no-fetch mode) |
| flag_clr | input | 3 | Flag clear pulse: [0] start, [1] end, [2] end-of-receive |
| periph_req | input | 1 | Peripheral request for flow control |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_write | output | 1 | 1 for a write, 0 for a read |
| mem_size | output | 2 | Beat size: 0 gives 1 byte, 1 gives 2, 2 gives 4 |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned, valid in the accepting cycle |
| active | output | 1 | Channel is running |
| stop_flag | output | 1 | Channel has stopped |
| start_flag | output | 1 | Sticky start-interrupt flag |
| end_flag | output | 1 | Sticky end-interrupt flag |
| eor_flag | output | 1 | Sticky end-of-receive flag |
| cur_desc | output | ADDR_W | Current next-descriptor pointer |
| cur_src | output | ADDR_W | Current source address |
| cur_dst | output | ADDR_W | Current target address |
| cur_cmd | output | 32 | Current command word with the written-back count |

## Verification
The hardest case to reach from the ports is end-of-receive. The request has to fall exactly between the last write of a burst and the channel's decision on whether to continue. A transfer that finishes, or a request that falls during a burst's reads, takes a different path. To hit that window, the bench counts write acknowledges in its memory responder and drops `periph_req` on the same falling edge on which it grants the last write of the first burst. The channel then decides on the next cycle with the request already low, which sets the flag. The same timing is used once with the stop enable and once with the jump enable.

// File: rtl/dce_pkg.sv
`timescale 1ns/1ps
package dce_pkg;
  localparam int LEN_W = 13;

  localparam int CMD_INC_SRC   = 31;
  localparam int CMD_INC_DST   = 30;
  localparam int CMD_FLOW_SRC  = 29;
  localparam int CMD_FLOW_DST  = 28;
  localparam int CMD_IRQ_START = 22;
  localparam int CMD_IRQ_END   = 21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ARM, ST_READ, ST_WRITE, ST_POST, ST_DONE
  } dce_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [1:0]       beat_size;
    logic [5:0]       burst_bytes;
    logic             inc_src;
    logic             inc_dst;
    logic             flow_src;
    logic             flow_dst;
    logic             irq_start;
    logic             irq_end;
  } cmd_view_t;
endpackage

// File: rtl/dce_cmd_decode.sv
`timescale 1ns/1ps
module dce_cmd_decode
  import dce_pkg::*;
(
  input  logic [31:0] cmd_word,
  output cmd_view_t   view
);
  logic unused_cmd;
  assign unused_cmd = ^{cmd_word[27:23], cmd_word[20:18], cmd_word[13]};

  always_comb begin
    view.len = cmd_word[LEN_W-1:0];
    case (cmd_word[15:14])
      2'd2:    view.beat_size = 2'd1;
      2'd3:    view.beat_size = 2'd2;
      default: view.beat_size = 2'd0;
    endcase
    view.burst_bytes = 6'd4 << cmd_word[17:16];
    view.inc_src     = cmd_word[CMD_INC_SRC];
    view.inc_dst     = cmd_word[CMD_INC_DST];
    view.flow_src    = cmd_word[CMD_FLOW_SRC];
    view.flow_dst    = cmd_word[CMD_FLOW_DST];
    view.irq_start   = cmd_word[CMD_IRQ_START];
    view.irq_end     = cmd_word[CMD_IRQ_END];
  end
endmodule

// File: rtl/dce_fetch_addr.sv
`timescale 1ns/1ps
module dce_fetch_addr #(
  parameter int ADDR_W      = 32,
  parameter int BRANCH_STEP = 32
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic              cmp_status,
  output logic [ADDR_W-1:0] base
);
  logic unused_ptr;
  assign unused_ptr = ^{ptr[3:2], ptr[0]};

  always_comb begin
    base = {ptr[ADDR_W-1:4], 4'b0000};
    if (ptr[1] && cmp_status) base = base + ADDR_W'(BRANCH_STEP);
  end
endmodule

// File: rtl/dce_burst_buf.sv
`timescale 1ns/1ps
module dce_burst_buf #(
  parameter int BYTES = 32,
  parameter int OFF_W = $clog2(BYTES) + 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [1:0]       wr_size,
  input  logic [31:0]      wr_data,
  input  logic [OFF_W-1:0] rd_off,
  input  logic [1:0]       rd_size,
  output logic [31:0]      rd_data
);
  localparam int IDX_W = $clog2(BYTES);

  logic [7:0]       cells [BYTES];
  logic [OFF_W-1:0] wr_nb;
  logic [OFF_W-1:0] rd_nb;

  assign wr_nb = OFF_W'(1) << wr_size;
  assign rd_nb = OFF_W'(1) << rd_size;

  for (genvar i = 0; i < BYTES; i++) begin : g_cell
    logic [OFF_W-1:0] lane;
    logic             hit;
    logic [7:0]       cell_q;
    assign lane = OFF_W'(i) - wr_off;
    assign hit  = wr_en && (OFF_W'(i) >= wr_off) && (lane < wr_nb);
    always_ff @(posedge clk) begin
      if (hit) cell_q <= 8'(wr_data >> {lane[1:0], 3'b000});
    end
    assign cells[i] = cell_q;
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [OFF_W-1:0] idx;
    assign idx = rd_off + OFF_W'(k);
    assign rd_data[8*k +: 8] = (OFF_W'(k) < rd_nb) ? cells[idx[IDX_W-1:0]] : 8'h00;
  end
endmodule

// File: rtl/dma_chain_engine.sv
`timescale 1ns/1ps
module dma_chain_engine
  import dce_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  input  logic              nodesc_mode,
  input  logic              eor_stop_en,
  input  logic              eor_jump_en,
  input  logic              cmp_status,
  input  logic [ADDR_W-1:0] prog_desc,
  input  logic [ADDR_W-1:0] prog_src,
  input  logic [ADDR_W-1:0] prog_dst,
  input  logic [31:0]       prog_cmd,
  input  logic [2:0]        flag_clr,
  input  logic              periph_req,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              active,
  output logic              stop_flag,
  output logic              start_flag,
  output logic              end_flag,
  output logic              eor_flag,
  output logic [ADDR_W-1:0] cur_desc,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [31:0]       cur_cmd
);
  localparam int OFF_W = $clog2(BUF_BYTES) + 1;

  dce_state_e        state_q;
  logic [ADDR_W-1:0] desc_q, src_q, dst_q, fbase_q;
  logic [31:0]       cmd_q, next_shadow_q;
  logic [1:0]        beat_q;
  logic [OFF_W-1:0]  off_q, burst_q;
  logic              active_q, stop_q, start_q, end_q, eor_q;

  cmd_view_t         cv;
  logic [ADDR_W-1:0] ptr_sel, fetch_base;
  logic [OFF_W-1:0]  beat_bytes, burst_cap, chunk, off_nx;
  logic              last_beat, flow_on, ack, starved;
  logic [31:0]       buf_rd;

  dce_cmd_decode u_dec (
    .cmd_word (cmd_q),
    .view     (cv)
  );

  assign ptr_sel = (state_q == ST_IDLE) ? prog_desc : desc_q;

  dce_fetch_addr #(.ADDR_W(ADDR_W)) u_fa (
    .ptr        (ptr_sel),
    .cmp_status (cmp_status),
    .base       (fetch_base)
  );

  dce_burst_buf #(.BYTES(BUF_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk     (clk),
    .wr_en   (state_q == ST_READ && ack),
    .wr_off  (off_q),
    .wr_size (cv.beat_size),
    .wr_data (mem_rdata),
    .rd_off  (off_q),
    .rd_size (cv.beat_size),
    .rd_data (buf_rd)
  );

  assign beat_bytes = OFF_W'(1) << cv.beat_size;
  assign burst_cap  = OFF_W'(cv.burst_bytes);
  assign chunk      = (cv.len < LEN_W'(burst_cap)) ? OFF_W'(cv.len) : burst_cap;
  assign off_nx     = off_q + beat_bytes;
  assign last_beat  = (off_nx >= burst_q);
  assign flow_on    = cv.flow_src | cv.flow_dst;
  assign starved    = flow_on && !periph_req;
  assign ack        = mem_valid && mem_ready;

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_size  = 2'd2;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_FETCH: begin
        mem_valid = 1'b1;
        mem_addr  = fbase_q + ADDR_W'({beat_q, 2'b00});
      end
      ST_READ: begin
        mem_valid = 1'b1;
        mem_size  = cv.beat_size;
        mem_addr  = src_q;
      end
      ST_WRITE: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_size  = cv.beat_size;
        mem_addr  = dst_q;
        mem_wdata = buf_rd;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      desc_q        <= '0;
      src_q         <= '0;
      dst_q         <= '0;
      fbase_q       <= '0;
      cmd_q         <= '0;
      next_shadow_q <= '0;
      beat_q        <= '0;
      off_q         <= '0;
      burst_q       <= '0;
      active_q      <= 1'b0;
      stop_q        <= 1'b1;
      start_q       <= 1'b0;
      end_q         <= 1'b0;
      eor_q         <= 1'b0;
    end else begin
      start_q <= start_q & ~flag_clr[0];
      end_q   <= end_q   & ~flag_clr[1];
      eor_q   <= eor_q   & ~flag_clr[2];
      case (state_q)
        ST_IDLE: begin
          if (run_start) begin
            active_q <= 1'b1;
            stop_q   <= 1'b0;
            desc_q   <= prog_desc;
            if (nodesc_mode) begin
              src_q   <= prog_src;
              dst_q   <= prog_dst;
              cmd_q   <= prog_cmd;
              state_q <= ST_ARM;
            end else begin
              fbase_q <= fetch_base;
              beat_q  <= '0;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (ack) begin
            beat_q <= beat_q + 2'd1;
            case (beat_q)
              2'd0: next_shadow_q <= mem_rdata;
              2'd1: src_q <= ADDR_W'(mem_rdata);
              2'd2: dst_q <= ADDR_W'(mem_rdata);
              default: begin
                cmd_q  <= mem_rdata;
                desc_q <= ADDR_W'(next_shadow_q);
                if (mem_rdata[CMD_FLOW_SRC]) src_q <= src_q & ~ADDR_W'(3);
                if (mem_rdata[CMD_FLOW_DST]) dst_q <= dst_q & ~ADDR_W'(3);
                if (mem_rdata[CMD_IRQ_START]) start_q <= 1'b1;
                state_q <= ST_ARM;
              end
            endcase
          end
        end
        ST_ARM: begin
          if (cv.len == '0) begin
            state_q <= ST_DONE;
          end else if (!starved) begin
            burst_q <= chunk;
            off_q   <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (ack) begin
            if (cv.inc_src) src_q <= src_q + ADDR_W'(beat_bytes);
            if (last_beat) begin
              off_q   <= '0;
              state_q <= ST_WRITE;
            end else begin
              off_q <= off_nx;
            end
          end
        end
        ST_WRITE: begin
          if (ack) begin
            if (cv.inc_dst) dst_q <= dst_q + ADDR_W'(beat_bytes);
            if (last_beat) begin
              cmd_q[LEN_W-1:0] <= cv.len - LEN_W'(burst_q);
              state_q          <= ST_POST;
            end else begin
              off_q <= off_nx;
            end
          end
        end
        ST_POST: begin
          if (cv.len == '0) begin
            state_q <= ST_DONE;
          end else if (starved) begin
            eor_q <= 1'b1;
            if (eor_stop_en) begin
              active_q <= 1'b0;
              stop_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (eor_jump_en && !nodesc_mode) begin
              fbase_q <= fetch_base;
              beat_q  <= '0;
              state_q <= ST_FETCH;
            end else begin
              state_q <= ST_ARM;
            end
          end else begin
            state_q <= ST_ARM;
          end
        end
        ST_DONE: begin
          if (cv.irq_end) end_q <= 1'b1;
          if (nodesc_mode || desc_q[0] || eor_stop_en) begin
            active_q <= 1'b0;
            stop_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            fbase_q <= fetch_base;
            beat_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active     = active_q;
  assign stop_flag  = stop_q;
  assign start_flag = start_q;
  assign end_flag   = end_q;
  assign eor_flag   = eor_q;
  assign cur_desc   = desc_q;
  assign cur_src    = src_q;
  assign cur_dst    = dst_q;
  assign cur_cmd    = cmd_q;
endmodule

// File: rtl/dma_chain_engine_chk.sv
`timescale 1ns/1ps
module dma_chain_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic              stop_flag,
  input logic              start_flag,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [1:0]        mem_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_valid);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_write) && $stable(mem_size));

  // R12
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && !mem_ready |=> $stable(mem_wdata));

  // R7
  stop_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> stop_flag);

  // R8
  start_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_flag) |-> active);
endmodule

bind dma_chain_engine dma_chain_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_chain_engine_bench.sv
`timescale 1ns/1ps
module dma_chain_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_start = 1'b0, nodesc_mode = 1'b0, eor_stop_en = 1'b0;
  logic        eor_jump_en = 1'b0, cmp_status = 1'b0;
  logic [31:0] prog_desc = '0, prog_src = '0, prog_dst = '0, prog_cmd = '0;
  logic [2:0]  flag_clr = '0;
  logic        periph_req = 1'b0;
  logic        mem_valid, mem_write, mem_ready = 1'b0;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        active, stop_flag, start_flag, end_flag, eor_flag;
  logic [31:0] cur_desc, cur_src, cur_dst, cur_cmd;

  always #2.5 clk = ~clk;

  dma_chain_engine u_dma_chain_engine (.*);

  int compared = 0, mismatched = 0, cycles = 0;
  logic [7:0] mem [4096];
  logic [7:0] mm  [4096];

  typedef struct { bit we; logic [31:0] addr; logic [1:0] size; logic [31:0] data; string tag; } acc_t;
  acc_t expq[$];
  bit   q_on = 1'b0;
  int   wr_count = 0, drop_at = -1, hs_count = 0;
  logic [7:0] lfsr = 8'h5a;

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem[(a + 3) & 12'hfff], mem[(a + 2) & 12'hfff], mem[(a + 1) & 12'hfff], mem[a & 12'hfff]};
  endfunction

  assign mem_rdata = rd32(mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder and per-handshake comparison against the model queue
  always @(negedge clk) begin
    bit rdy;
    cycles++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy = lfsr[0] | lfsr[3];
    mem_ready = rdy;
    if (mem_valid && rdy) begin
      hs_count++;
      if (q_on) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2", "unexpected access", mem_addr, 32'hx);
        end else begin
          acc_t e;
          logic [31:0] m;
          e = expq.pop_front();
          m = (e.size == 2'd0) ? 32'hff : (e.size == 2'd1) ? 32'hffff : 32'hffffffff;
          chk(mem_write == e.we, e.tag, "direction", {31'b0, mem_write}, {31'b0, e.we});
          chk(mem_addr == e.addr, e.tag, "address", mem_addr, e.addr);
          chk(mem_size == e.size, e.tag, "size", {30'b0, mem_size}, {30'b0, e.size});
          if (e.we) chk((mem_wdata & m) == (e.data & m), e.tag, "write data", mem_wdata & m, e.data & m);
        end
      end
      if (mem_write) begin
        for (int k = 0; k < (1 << mem_size); k++) mem[(mem_addr + k) & 12'hfff] = mem_wdata[8*k +: 8];
        wr_count++;
        if (wr_count == drop_at) periph_req = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic put32(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[(a + k) & 12'hfff] = v[8*k +: 8];
  endtask

  function automatic logic [31:0] mm32(input logic [31:0] a);
    return {mm[(a + 3) & 12'hfff], mm[(a + 2) & 12'hfff], mm[(a + 1) & 12'hfff], mm[a & 12'hfff]};
  endfunction

  function automatic logic [31:0] mkcmd(input int len, input int wc, input int bc,
      input bit is, input bit id, input bit fs, input bit fd, input bit sq, input bit eq);
    logic [31:0] c;
    c = '0;
    c[12:0] = 13'(len); c[15:14] = 2'(wc); c[17:16] = 2'(bc);
    c[31] = is; c[30] = id; c[29] = fs; c[28] = fd; c[22] = sq; c[21] = eq;
    return c;
  endfunction

  // behavioural model: produces the ordered list of memory accesses
  task automatic model(input logic [31:0] ptr0, input bit nod, input bit cmp, input bit stp,
                       input logic [31:0] s0, input logic [31:0] d0, input logic [31:0] c0);
    logic [31:0] ptr, desc, s, d, c, base;
    logic [7:0]  bb [32];
    int len, wb, n;
    logic [1:0] sz;
    for (int i = 0; i < 4096; i++) mm[i] = mem[i];
    ptr = ptr0; desc = ptr0; s = s0; d = d0; c = c0;
    for (int dn = 0; dn < 8; dn++) begin
      if (!nod) begin
        base = {ptr[31:4], 4'h0} + ((ptr[1] && cmp) ? 32'd32 : 32'd0);
        for (int w = 0; w < 4; w++)
          expq.push_back('{1'b0, base + 32'(4 * w), 2'd2, 32'h0, (ptr[1] && cmp) ? "R3" : "R2"});
        desc = mm32(base); s = mm32(base + 4); d = mm32(base + 8); c = mm32(base + 12);
        if (c[29]) s[1:0] = 2'b00;
        if (c[28]) d[1:0] = 2'b00;
      end
      wb = (c[15:14] == 2) ? 2 : (c[15:14] == 3) ? 4 : 1;
      sz = (wb == 4) ? 2'd2 : (wb == 2) ? 2'd1 : 2'd0;
      len = int'(c[12:0]);
      while (len > 0) begin
        n = (len < (4 << c[17:16])) ? len : (4 << c[17:16]);
        for (int o = 0; o < n; o += wb) begin
          expq.push_back('{1'b0, s, sz, 32'h0, "R4"});
          for (int k = 0; k < wb; k++) bb[o + k] = mm[(s + k) & 12'hfff];
          if (c[31]) s = s + 32'(wb);
        end
        for (int o = 0; o < n; o += wb) begin
          logic [31:0] v;
          v = '0;
          for (int k = 0; k < wb; k++) begin
            v[8*k +: 8] = bb[o + k];
            mm[(d + k) & 12'hfff] = bb[o + k];
          end
          expq.push_back('{1'b1, d, sz, v, c[30] ? "R5" : "R4"});
          if (c[30]) d = d + 32'(wb);
        end
        len -= n;
      end
      if (nod || desc[0] || stp) break;
      ptr = desc;
    end
  endtask

  task automatic start_and_wait();
    @(negedge clk); run_start = 1'b1;
    @(negedge clk); run_start = 1'b0;
    for (int i = 0; i < 5000 && active; i++) @(negedge clk);
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  task automatic fill(input logic [31:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) mem[(a + i) & 12'hfff] = seed + 8'(i * 7);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!active && stop_flag, "R1", "active/stop", {30'b0, active, stop_flag}, 32'h1);
    chk(!start_flag && !end_flag && !eor_flag, "R1", "flags", {29'b0, start_flag, end_flag, eor_flag}, 32'h0);
    chk(!mem_valid, "R1", "mem_valid", {31'b0, mem_valid}, 32'h0);

    // single descriptor, stop bit, width 4, burst 8
    put32(32'h100, 32'h1); put32(32'h104, 32'h400); put32(32'h108, 32'h600);
    put32(32'h10c, mkcmd(24, 3, 1, 1, 1, 0, 0, 1, 1));
    fill(32'h400, 24, 8'h11);
    prog_desc = 32'h100;
    model(32'h100, 0, 0, 0, 0, 0, 0);
    q_on = 1'b1; start_and_wait(); q_on = 1'b0;
    chk(expq.size() == 0, "R2", "accesses left", 32'(expq.size()), 32'h0);
    chk(start_flag, "R8", "start flag", {31'b0, start_flag}, 32'h1);
    chk(end_flag, "R8", "end flag", {31'b0, end_flag}, 32'h1);
    chk(cur_cmd[12:0] == 13'd0, "R6", "remaining", {19'b0, cur_cmd[12:0]}, 32'h0);
    chk(cur_src == 32'h418 && cur_dst == 32'h618, "R5", "final src", cur_src, 32'h418);
    chk(!active && stop_flag, "R7", "stopped", {30'b0, active, stop_flag}, 32'h1);
    begin
      bit same;
      same = 1'b1;
      for (int i = 0; i < 24; i++) if (mem[12'h600 + i] != mem[12'h400 + i]) same = 1'b0;
      chk(same, "R4", "copied data", {31'b0, same}, 32'h1);
    end
    expq.delete();

    // two-descriptor chain: byte beats with split burst, then fixed source
    clear_flags(3'b111);
    put32(32'h140, 32'h180); put32(32'h144, 32'h480); put32(32'h148, 32'h700);
    put32(32'h14c, mkcmd(40, 1, 3, 1, 1, 0, 0, 0, 1));
    put32(32'h180, 32'h1c1); put32(32'h184, 32'h4c0); put32(32'h188, 32'h780);
    put32(32'h18c, mkcmd(8, 2, 0, 0, 1, 0, 0, 0, 0));
    fill(32'h480, 48, 8'h3c); fill(32'h4c0, 8, 8'h90);
    prog_desc = 32'h140;
    model(32'h140, 0, 0, 0, 0, 0, 0);
    q_on = 1'b1; start_and_wait(); q_on = 1'b0;
    chk(expq.size() == 0, "R7", "chain accesses left", 32'(expq.size()), 32'h0);
    chk(cur_desc == 32'h1c1, "R7", "final pointer", cur_desc, 32'h1c1);
    chk(cur_src == 32'h4c0, "R5", "fixed source", cur_src, 32'h4c0);
    chk(cur_dst == 32'h788, "R5", "stepped target", cur_dst, 32'h788);
    expq.delete();

    // branch taken and not taken
    put32(32'h200, 32'h1); put32(32'h204, 32'h5a0); put32(32'h208, 32'h900);
    put32(32'h20c, mkcmd(8, 3, 1, 1, 1, 0, 0, 0, 0));
    put32(32'h220, 32'h1); put32(32'h224, 32'h500); put32(32'h228, 32'h800);
    put32(32'h22c, mkcmd(8, 3, 1, 1, 1, 0, 0, 0, 0));
    prog_desc = 32'h202; cmp_status = 1'b1;
    model(32'h202, 0, 1, 0, 0, 0, 0);
    q_on = 1'b1; start_and_wait(); q_on = 1'b0;
    chk(cur_src == 32'h508, "R3", "branch taken source", cur_src, 32'h508);
    expq.delete();
    cmp_status = 1'b0;
    model(32'h202, 0, 0, 0, 0, 0, 0);
    q_on = 1'b1; start_and_wait(); q_on = 1'b0;
    chk(cur_src == 32'h5a8, "R3", "branch not taken source", cur_src, 32'h5a8);
    expq.delete();

    // no-descriptor-fetch mode
    clear_flags(3'b111);
    nodesc_mode = 1'b1; prog_desc = 32'h0; prog_src = 32'h540; prog_dst = 32'h840;
    prog_cmd = mkcmd(12, 3, 1, 1, 1, 0, 0, 1, 1);
    fill(32'h540, 12, 8'h77);
    model(32'h0, 1, 0, 0, 32'h540, 32'h840, prog_cmd);
    q_on = 1'b1; start_and_wait(); q_on = 1'b0;
    chk(expq.size() == 0, "R11", "no-fetch accesses left", 32'(expq.size()), 32'h0);
    chk(!start_flag, "R11", "no start flag", {31'b0, start_flag}, 32'h0);
    chk(end_flag && cur_src == 32'h54c, "R11", "end of no-fetch run", cur_src, 32'h54c);
    nodesc_mode = 1'b0;
    expq.delete();

    // flow control wait with address masking
    put32(32'h240, 32'h1); put32(32'h244, 32'h563); put32(32'h248, 32'h860);
    put32(32'h24c, mkcmd(8, 3, 1, 1, 1, 1, 0, 0, 0));
    prog_desc = 32'h240; periph_req = 1'b0;
    model(32'h240, 0, 0, 0, 0, 0, 0);
    q_on = 1'b1;
    @(negedge clk); run_start = 1'b1;
    @(negedge clk); run_start = 1'b0;
    hs_count = 0;
    repeat (40) @(negedge clk);
    chk(hs_count == 4, "R9", "gated accesses", 32'(hs_count), 32'd4);
    chk(cur_src == 32'h560, "R9", "masked source", cur_src, 32'h560);
    periph_req = 1'b1;
    for (int i = 0; i < 5000 && active; i++) @(negedge clk);
    q_on = 1'b0;
    chk(expq.size() == 0 && cur_src == 32'h568, "R9", "flow run", cur_src, 32'h568);
    expq.delete();

    // end-of-receive with stop
    clear_flags(3'b111);
    put32(32'h280, 32'h2c0); put32(32'h284, 32'h580); put32(32'h288, 32'h880);
    put32(32'h28c, mkcmd(16, 3, 1, 1, 0, 0, 1, 0, 1));
    put32(32'h2c0, 32'h1); put32(32'h2c4, 32'h5c0); put32(32'h2c8, 32'h8c0);
    put32(32'h2cc, mkcmd(8, 3, 1, 1, 1, 0, 0, 1, 1));
    prog_desc = 32'h280; eor_stop_en = 1'b1; periph_req = 1'b1;
    drop_at = wr_count + 2;
    start_and_wait();
    chk(eor_flag, "R10", "eor flag on stop", {31'b0, eor_flag}, 32'h1);
    chk(!active && stop_flag, "R10", "stopped on eor", {30'b0, active, stop_flag}, 32'h1);
    chk(cur_cmd[12:0] == 13'd8, "R10", "remaining after eor", {19'b0, cur_cmd[12:0]}, 32'd8);
    chk(cur_src == 32'h588 && cur_dst == 32'h880, "R10", "addresses after eor", cur_src, 32'h588);
    chk(!end_flag, "R8", "no end flag", {31'b0, end_flag}, 32'h0);

    // end-of-receive with jump
    clear_flags(3'b111);
    eor_stop_en = 1'b0; eor_jump_en = 1'b1; periph_req = 1'b1;
    drop_at = wr_count + 2;
    start_and_wait();
    chk(eor_flag && start_flag, "R10", "eor jump flags", {30'b0, eor_flag, start_flag}, 32'h3);
    chk(cur_src == 32'h5c8 && cur_desc == 32'h1, "R10", "jumped descriptor", cur_src, 32'h5c8);
    chk(end_flag && !active, "R10", "jumped run finished", {30'b0, end_flag, active}, 32'h2);
    eor_jump_en = 1'b0; drop_at = -1;

    // selective flag clearing
    clear_flags(3'b010);
    chk(!end_flag && start_flag && eor_flag, "R13", "clear end only",
        {29'b0, start_flag, end_flag, eor_flag}, 32'h5);
    clear_flags(3'b101);
    chk(!start_flag && !eor_flag, "R13", "clear rest",
        {29'b0, start_flag, end_flag, eor_flag}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule